// File: doc/BRIEF.md
# Per-Lane Write Calibration Sweeper

This controller searches for a working write-path setting on every byte lane of a memory interface. Each trial sets the delay and latency outputs, waits a programmable settle time, and then asks an external pattern engine to run one write and read-back test. The engine answers with one match bit per lane, or with a timeout. Each enabled lane keeps the first write offset at which its data matched. Lanes that have not yet passed keep stepping through the offset range. If any enabled lane is still failing after the last offset, the write latency is raised by one and the whole offset sweep starts again.

When the optional data-delay mode is selected, a second pass follows a successful write sweep. It steps a shared data output delay across its full range, one trial per step. For each lane it records the lower and upper edges of the first passing window, and when the sweep ends it drives the centre of that window on the lane's delay output. The status code reports the overall result: 0xFF for success, 0xFE for failure.

Top module: `wrcal_sweeper`

## Requirements
- R1: After reset, status is 0x00, `test_req` and `busy` are low, and `wr_lat`, `wr_ofs`, `dq_dly` and `lane_ok` are all zero.
- R2: Before each rising edge of `test_req`, the values on `wr_ofs`, `wr_lat` and `dq_dly` stay unchanged for at least `settle_cnt`+1 cycles. They also stay unchanged for as long as `test_req` is high.
- R3: `test_req` stays high until a cycle in which `test_ack` is high, and it is low in the next cycle. `test_pass` and `test_timeout` are used only in that acknowledge cycle.
- R4: Every enabled lane starts a sweep at offset 0. Lane i's offset is field `wr_ofs[3*i+2:3*i]`. After a failed trial the offset steps up by one, up to a limit of 7. The first passing offset is frozen and sets bit i of `lane_ok`, while the remaining lanes keep sweeping.
- R5: A trial that ends with `test_timeout` high counts as a failure on every lane, whatever the value of `test_pass`.
- R6: Suppose that after the trial at offset 7 some enabled lane has still not passed, and `wr_lat` is below 3. Then `wr_lat` rises by one, every offset and `lane_ok` bit is cleared, and the sweep starts again from offset 0.
- R7: If that condition occurs while `wr_lat` is 3, the run ends with status 0xFE and `wr_lat` left at 3. Each lane keeps its final offset and `lane_ok` bit.
- R8: As soon as every enabled lane has passed, the write sweep stops with no further trials. If `dq_mode` was low at start, the run ends with status 0xFF.
- R9: A disabled lane never sets its `lane_ok` or found bit, and its offset stays 0, whatever `test_pass` reports for it. `lane_en` and `dq_mode` are sampled only when a run starts.
- R10: In data-delay mode, after a successful write sweep the block runs 16 trials with `dq_dly` fields (lane i at `dq_dly[4*i+3:4*i]`) all set to 0, 1, … 15. `dq_lo` receives the first passing delay and `dq_hi` the last passing delay of the first contiguous passing run. `dq_found` marks the lanes that passed at least once.
- R11: When a data-delay sweep ends, each found lane drives (`dq_lo`+`dq_hi`)>>1 on its `dq_dly` field. Lanes that were not found drive 0, and the status becomes 0xFF.
- R12: A `start` pulse while `busy` is high is ignored. The run in progress continues with the settings it latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a calibration run when idle |
| lane_en | input | 5 | Lanes to calibrate |
| dq_mode | input | 1 | Adds the data-delay window pass |
| settle_cnt | input | 8 | Extra settle cycles before each trial |
| test_req | output | 1 | Asks the pattern engine for one trial |
| test_ack | input | 1 | Trial result valid |
| test_pass | input | 5 | Per-lane data match of the trial |
| test_timeout | input | 1 | Trial timed out |
| wr_lat | output | 2 | Current write latency setting |
| wr_ofs | output | 15 | Per-lane write offset, 3 bits per lane |
| dq_dly | output | 20 | Per-lane data output delay, 4 bits per lane |
| lane_ok | output | 5 | Per-lane write pass bitmap |
| dq_found | output | 5 | Per-lane data window found |
| dq_lo | output | 20 | Per-lane lower window edge |
| dq_hi | output | 20 | Per-lane upper window edge |
| busy | output | 1 | Run in progress |
| status | output | 8 | 0x00 idle or running, 0xFF passed, 0xFE failed |

## Verification
The assertions assume that the pattern engine raises `test_ack` only while `test_req` is high, and that it holds `test_ack` for a single cycle. They also assume that `start` comes from a synchronous source. The bench's engine model answers only after it has seen the request, after a configurable number of cycles. It drops the acknowledge in the next cycle, and it derives each lane's match from the latency, offset and delay the block is driving at that moment. Timeouts are injected only on chosen trial numbers of the write sweep.

// File: rtl/wrcal_pkg.sv
// Shared types and status codes for the write calibration sweeper.
package wrcal_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETTLE = 2'd1,
        SQ_REQ    = 2'd2
    } sq_state_t;

    localparam logic [7:0] ST_NONE = 8'h00;
    localparam logic [7:0] ST_PASS = 8'hFF;
    localparam logic [7:0] ST_FAIL = 8'hFE;
endpackage

// File: rtl/wrcal_settle_timer.sv
// Settle timer: counts cycles after a restart and flags when the count
// reaches the programmed limit. Assumes restart is a single-cycle pulse
// issued whenever the sequencer changes any driven setting.
module wrcal_settle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == limit);

    // Counts up from zero after each restart and saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wrcal_lane.sv
// Per-lane calibration state: write offset search with pass latch, and the
// data-delay window edge tracker with centre computation. Assumes the
// sequencer pulses the eval strobes only in the cycle a trial result is valid
// and keeps en constant for the duration of a run.
module wrcal_lane #(
    parameter int OW = 3,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          clr_wr,
    input  logic          wr_eval,
    input  logic          dq_eval,
    input  logic          dq_fin,
    input  logic          dq_active,
    input  logic          en,
    input  logic          pass,
    input  logic [DW-1:0] dq_step,
    output logic          ok,
    output logic [OW-1:0] ofs,
    output logic          found,
    output logic [DW-1:0] lo,
    output logic [DW-1:0] hi,
    output logic [DW-1:0] dly
);
    localparam logic [OW-1:0] OFS_TOP = {OW{1'b1}};

    logic          ok_q;
    logic [OW-1:0] ofs_q;
    logic          seen_q;
    logic          closed_q;
    logic          fin_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;
    logic [DW:0]   sum;
    logic [DW-1:0] centre;

    // Write offset search: freeze at the first pass, otherwise step upward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q  <= 1'b0;
            ofs_q <= '0;
        end else if (clr_all || clr_wr) begin
            ok_q  <= 1'b0;
            ofs_q <= '0;
        end else if (wr_eval && en && !ok_q) begin
            if (pass)
                ok_q <= 1'b1;
            else if (ofs_q != OFS_TOP)
                ofs_q <= ofs_q + 1'b1;
        end
    end

    // Window tracker: first pass opens, first fail after it closes the window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            seen_q   <= 1'b0;
            closed_q <= 1'b0;
            fin_q    <= 1'b0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else begin
            if (dq_fin)
                fin_q <= 1'b1;
            if (dq_eval && en) begin
                if (pass) begin
                    if (!seen_q) begin
                        seen_q <= 1'b1;
                        lo_q   <= dq_step;
                        hi_q   <= dq_step;
                    end else if (!closed_q) begin
                        hi_q <= dq_step;
                    end
                end else if (seen_q) begin
                    closed_q <= 1'b1;
                end
            end
        end
    end

    // Centre of the window and the delay driven on this lane.
    always_comb begin
        sum    = {1'b0, lo_q} + {1'b0, hi_q};
        centre = sum[DW:1];
        if (fin_q)
            dly = seen_q ? centre : '0;
        else if (dq_active)
            dly = dq_step;
        else
            dly = '0;
    end

    assign ok    = ok_q;
    assign ofs   = ofs_q;
    assign found = seen_q;
    assign lo    = lo_q;
    assign hi    = hi_q;

    // R4: a passed lane stays passed until a clear.
    a_r4_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ok_q && !clr_all && !clr_wr |=> ok_q);
    // R4: a passed lane keeps its offset until a clear.
    a_r4_ofs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ok_q && !clr_all && !clr_wr |=> $stable(ofs_q));
    // R9: a disabled lane shows no result.
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!ok_q && ofs_q == '0 && !seen_q));
    // R10: the window edges are ordered.
    a_r10_window_order: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> lo_q <= hi_q);
endmodule

// File: rtl/wrcal_seq.sv
// Run sequencer: latches the run settings, steps the shared offset, the
// latency and the data delay, handles the trial handshake, and decides
// retry, pass and fail. Assumes test_ack is a one-cycle pulse given only
// while test_req is high.
module wrcal_seq
    import wrcal_pkg::*;
#(
    parameter int NL      = 5,
    parameter int OW      = 3,
    parameter int DW      = 4,
    parameter int LAT_MAX = 3,
    parameter int LW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NL-1:0] lane_en,
    input  logic          dq_mode,
    input  logic [NL-1:0] lane_ok,
    input  logic          test_ack,
    input  logic [NL-1:0] test_pass,
    input  logic          test_timeout,
    input  logic          expired,
    output logic          restart,
    output logic          clr_all,
    output logic          clr_wr,
    output logic          wr_eval,
    output logic          dq_eval,
    output logic          dq_fin,
    output logic          dq_active,
    output logic [NL-1:0] en_q,
    output logic [NL-1:0] pass_eff,
    output logic [DW-1:0] dq_step,
    output logic [LW-1:0] lat,
    output logic          test_req,
    output logic          busy,
    output logic [7:0]    status
);
    localparam logic [OW-1:0] OFS_TOP = {OW{1'b1}};
    localparam logic [DW-1:0] DLY_TOP = {DW{1'b1}};
    localparam logic [LW-1:0] LAT_TOP = LW'(LAT_MAX);

    sq_state_t     state_q, state_d;
    logic          ph_dq_q, dqm_q;
    logic [OW-1:0] step_q;
    logic [DW-1:0] dly_q;
    logic [LW-1:0] lat_q;
    logic [7:0]    status_q;

    logic start_go, got, all_ok_nx, wr_last, dq_last, lat_top;
    logic wr_done_ok, wr_retry, wr_give_up, wr_next, to_dq, pass_end;

    // Trial outcome decode and next-state selection.
    always_comb begin
        pass_eff   = test_pass & ~{NL{test_timeout}};
        all_ok_nx  = &(lane_ok | pass_eff | ~en_q);
        start_go   = (state_q == SQ_IDLE) && start;
        got        = (state_q == SQ_REQ) && test_ack;
        wr_eval    = got && !ph_dq_q;
        dq_eval    = got && ph_dq_q;
        wr_last    = (step_q == OFS_TOP);
        dq_last    = (dly_q == DLY_TOP);
        lat_top    = (lat_q == LAT_TOP);
        wr_done_ok = wr_eval && all_ok_nx;
        wr_retry   = wr_eval && !all_ok_nx && wr_last && !lat_top;
        wr_give_up = wr_eval && !all_ok_nx && wr_last && lat_top;
        wr_next    = wr_eval && !all_ok_nx && !wr_last;
        to_dq      = wr_done_ok && dqm_q;
        dq_fin     = dq_eval && dq_last;
        pass_end   = (wr_done_ok && !dqm_q) || dq_fin;
        clr_all    = start_go;
        clr_wr     = wr_retry;
        case (state_q)
            SQ_IDLE:   state_d = start_go ? SQ_SETTLE : SQ_IDLE;
            SQ_SETTLE: state_d = expired ? SQ_REQ : SQ_SETTLE;
            SQ_REQ: begin
                if (!got)
                    state_d = SQ_REQ;
                else if (pass_end || wr_give_up)
                    state_d = SQ_IDLE;
                else
                    state_d = SQ_SETTLE;
            end
            default:   state_d = SQ_IDLE;
        endcase
        restart = (state_q != SQ_SETTLE) && (state_d == SQ_SETTLE);
    end

    // Run registers: settings latch, sweep counters and final status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            ph_dq_q  <= 1'b0;
            dqm_q    <= 1'b0;
            en_q     <= '0;
            step_q   <= '0;
            dly_q    <= '0;
            lat_q    <= '0;
            status_q <= ST_NONE;
        end else begin
            state_q <= state_d;
            if (start_go) begin
                en_q     <= lane_en;
                dqm_q    <= dq_mode;
                ph_dq_q  <= 1'b0;
                step_q   <= '0;
                dly_q    <= '0;
                lat_q    <= '0;
                status_q <= ST_NONE;
            end
            if (to_dq) begin
                ph_dq_q <= 1'b1;
                dly_q   <= '0;
            end
            if (wr_next)
                step_q <= step_q + 1'b1;
            if (wr_retry) begin
                step_q <= '0;
                lat_q  <= lat_q + 1'b1;
            end
            if (dq_eval && !dq_last)
                dly_q <= dly_q + 1'b1;
            if (pass_end)
                status_q <= ST_PASS;
            if (wr_give_up)
                status_q <= ST_FAIL;
        end
    end

    assign test_req  = (state_q == SQ_REQ);
    assign busy      = (state_q != SQ_IDLE);
    assign status    = status_q;
    assign lat       = lat_q;
    assign dq_step   = dly_q;
    assign dq_active = ph_dq_q;

    // R3: the request is held until acknowledged.
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        test_req && !test_ack |=> test_req);
    // R3: the request drops right after the acknowledge.
    a_r3_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        test_req && test_ack |=> !test_req);
    // R6: within a run the latency only moves up by one.
    a_r6_lat_steps: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && (lat_q != $past(lat_q)) |-> lat_q == $past(lat_q) + 1'b1);
    // R7: failure is only reported at the top latency.
    a_r7_fail_top: assert property (@(posedge clk) disable iff (!rst_n)
        status_q == ST_FAIL |-> lat_q == LAT_TOP);
endmodule

// File: rtl/wrcal_sweeper.sv
// Per-lane write calibration sweeper top: joins the sequencer, the settle
// timer and one lane tracker per byte lane. Assumes an external pattern
// engine that answers each request with one acknowledge pulse.
module wrcal_sweeper #(
    parameter int NUM_LANES = 5,
    parameter int OFS_W     = 3,
    parameter int DLY_W     = 4,
    parameter int LAT_MAX   = 3,
    parameter int SETTLE_W  = 8,
    parameter int LAT_W     = $clog2(LAT_MAX + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NUM_LANES-1:0]       lane_en,
    input  logic                       dq_mode,
    input  logic [SETTLE_W-1:0]        settle_cnt,
    output logic                       test_req,
    input  logic                       test_ack,
    input  logic [NUM_LANES-1:0]       test_pass,
    input  logic                       test_timeout,
    output logic [LAT_W-1:0]           wr_lat,
    output logic [NUM_LANES*OFS_W-1:0] wr_ofs,
    output logic [NUM_LANES*DLY_W-1:0] dq_dly,
    output logic [NUM_LANES-1:0]       lane_ok,
    output logic [NUM_LANES-1:0]       dq_found,
    output logic [NUM_LANES*DLY_W-1:0] dq_lo,
    output logic [NUM_LANES*DLY_W-1:0] dq_hi,
    output logic                       busy,
    output logic [7:0]                 status
);
    logic                 restart, expired;
    logic                 clr_all, clr_wr, wr_eval, dq_eval, dq_fin, dq_active;
    logic [NUM_LANES-1:0] en_q, pass_eff;
    logic [DLY_W-1:0]     dq_step;

    wrcal_seq #(
        .NL(NUM_LANES), .OW(OFS_W), .DW(DLY_W), .LAT_MAX(LAT_MAX), .LW(LAT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_en(lane_en),
        .dq_mode(dq_mode), .lane_ok(lane_ok), .test_ack(test_ack),
        .test_pass(test_pass), .test_timeout(test_timeout), .expired(expired),
        .restart(restart), .clr_all(clr_all), .clr_wr(clr_wr),
        .wr_eval(wr_eval), .dq_eval(dq_eval), .dq_fin(dq_fin),
        .dq_active(dq_active), .en_q(en_q), .pass_eff(pass_eff),
        .dq_step(dq_step), .lat(wr_lat), .test_req(test_req),
        .busy(busy), .status(status)
    );

    wrcal_settle_timer #(.CW(SETTLE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .limit(settle_cnt), .expired(expired)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        wrcal_lane #(.OW(OFS_W), .DW(DLY_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .clr_wr(clr_wr),
            .wr_eval(wr_eval), .dq_eval(dq_eval), .dq_fin(dq_fin),
            .dq_active(dq_active), .en(en_q[g]), .pass(pass_eff[g]),
            .dq_step(dq_step), .ok(lane_ok[g]),
            .ofs(wr_ofs[g*OFS_W +: OFS_W]), .found(dq_found[g]),
            .lo(dq_lo[g*DLY_W +: DLY_W]), .hi(dq_hi[g*DLY_W +: DLY_W]),
            .dly(dq_dly[g*DLY_W +: DLY_W])
        );
    end

    // R2: driven settings do not move while a trial is requested.
    a_r2_outputs_steady: assert property (@(posedge clk) disable iff (!rst_n)
        test_req |-> ($stable(wr_ofs) && $stable(wr_lat) && $stable(dq_dly)));
endmodule

// File: tb/sim_wrcal_sweeper.sv
// Scoreboard bench: the driver pushes expected results per run, an engine
// model answers trials, and a monitor compares when busy falls.
module sim_wrcal_sweeper;
    localparam int NL = 5, OW = 3, DW = 4, LW = 2, SW = 8;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dq_mode = 1'b0;
    logic test_ack = 1'b0, test_timeout = 1'b0;
    logic [NL-1:0] lane_en = '0, test_pass = '0;
    logic [SW-1:0] settle_cnt = '0;
    logic test_req, busy;
    logic [LW-1:0] wr_lat;
    logic [NL*OW-1:0] wr_ofs;
    logic [NL*DW-1:0] dq_dly, dq_lo, dq_hi;
    logic [NL-1:0] lane_ok, dq_found;
    logic [7:0] status;

    always #2.5 clk = ~clk;

    wrcal_sweeper u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_en(lane_en),
        .dq_mode(dq_mode), .settle_cnt(settle_cnt), .test_req(test_req),
        .test_ack(test_ack), .test_pass(test_pass), .test_timeout(test_timeout),
        .wr_lat(wr_lat), .wr_ofs(wr_ofs), .dq_dly(dq_dly), .lane_ok(lane_ok),
        .dq_found(dq_found), .dq_lo(dq_lo), .dq_hi(dq_hi), .busy(busy),
        .status(status)
    );

    typedef struct {
        int    kind;
        int    lane;
        int    exp;
        string tag;
    } item_t;
    item_t sbq[$];

    int go[NL], gl[NL], wa1[NL], wb1[NL], wa2[NL], wb2[NL];
    logic [63:0] tmask = '0;
    int resp_lat = 0, wr_trials_exp = 0, trial_no = 0;
    int n_chk = 0, n_bad = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int actual(input int k, input int l);
        case (k)
            0: return int'(status);
            1: return int'(wr_lat);
            2: return int'(lane_ok[l]);
            3: return int'(wr_ofs[l*OW +: OW]);
            4: return int'(dq_found[l]);
            5: return int'(dq_lo[l*DW +: DW]);
            6: return int'(dq_hi[l*DW +: DW]);
            7: return int'(dq_dly[l*DW +: DW]);
            default: return trial_no;
        endcase
    endfunction

    function automatic void push(input int k, input int l, input int e, input string t);
        item_t it;
        it.kind = k; it.lane = l; it.exp = e; it.tag = t;
        sbq.push_back(it);
    endfunction

    task automatic set_lane(input int i, input int l_gl, input int l_go,
                            input int a1, input int b1, input int a2, input int b2);
        gl[i] = l_gl; go[i] = l_go; wa1[i] = a1; wb1[i] = b1; wa2[i] = a2; wb2[i] = b2;
    endtask

    // Expected results derived from the requirements (R4..R11).
    task automatic expect_run(input logic [NL-1:0] en, input bit dqm,
                              input string ofs_tag, input string cnt_tag);
        int okb[NL], ofs[NL], lo[NL], hi[NL], fnd[NL], dly[NL];
        int trial, lat;
        bit pass_all, to, all, p, seen, closed;
        trial = 0; lat = 0; pass_all = 0;
        for (int l = 0; l <= 3 && !pass_all; l++) begin
            lat = l;
            for (int i = 0; i < NL; i++) begin okb[i] = 0; ofs[i] = 0; end
            for (int s = 0; s <= 7 && !pass_all; s++) begin
                to = (trial < 64) ? tmask[trial] : 1'b0;
                for (int i = 0; i < NL; i++)
                    if (en[i] && okb[i] == 0) begin
                        ofs[i] = s;
                        if (!to && l >= gl[i] && s >= go[i]) okb[i] = 1;
                    end
                trial++;
                all = 1;
                for (int i = 0; i < NL; i++) if (en[i] && okb[i] == 0) all = 0;
                pass_all = all;
            end
        end
        wr_trials_exp = trial;
        for (int i = 0; i < NL; i++) begin lo[i] = 0; hi[i] = 0; fnd[i] = 0; dly[i] = 0; end
        if (pass_all && dqm) begin
            for (int i = 0; i < NL; i++) begin
                seen = 0; closed = 0;
                if (en[i])
                    for (int d = 0; d < 16; d++) begin
                        p = (d >= wa1[i] && d <= wb1[i]) || (d >= wa2[i] && d <= wb2[i]);
                        if (p) begin
                            if (!seen) begin seen = 1; lo[i] = d; hi[i] = d; end
                            else if (!closed) hi[i] = d;
                        end else if (seen) closed = 1;
                    end
                fnd[i] = seen;
                dly[i] = seen ? (lo[i] + hi[i]) / 2 : 0;
            end
            trial += 16;
        end
        push(0, 0, pass_all ? 255 : 254, pass_all ? "R8" : "R7");
        push(1, 0, lat, "R6");
        for (int i = 0; i < NL; i++) begin
            push(2, i, okb[i], en[i] ? ofs_tag : "R9");
            push(3, i, ofs[i], en[i] ? ofs_tag : "R9");
            push(4, i, fnd[i], "R10");
            push(5, i, lo[i], "R10");
            push(6, i, hi[i], "R10");
            push(7, i, dly[i], "R11");
        end
        push(8, 0, trial, cnt_tag);
    endtask

    // Pattern engine model plus settle (R2) and handshake (R3) observation.
    initial begin
        logic [NL*OW+LW+NL*DW-1:0] cur, prev;
        int stab, wcnt, d;
        bit req_prev, p;
        stab = 0; wcnt = 0; req_prev = 0; prev = '0;
        forever begin
            @(negedge clk);
            cur = {wr_ofs, wr_lat, dq_dly};
            if (cur != prev) stab = 0; else stab++;
            prev = cur;
            if (rst_n && test_req && !req_prev) begin
                n_chk++;
                if (stab < int'(settle_cnt) + 1) begin
                    n_bad++;
                    $display("FAIL R2 steady cycles before request: actual=%0d expected>=%0d",
                             stab, int'(settle_cnt) + 1);
                end
            end
            req_prev = test_req;
            if (test_ack) begin
                check("R3", "request after acknowledge", int'(test_req), 0);
                test_ack = 0; test_pass = '0; test_timeout = 0;
            end else if (test_req) begin
                if (wcnt >= resp_lat) begin
                    for (int i = 0; i < NL; i++) begin
                        if (trial_no < wr_trials_exp)
                            p = (int'(wr_lat) >= gl[i]) && (int'(wr_ofs[i*OW +: OW]) >= go[i]);
                        else begin
                            d = int'(dq_dly[i*DW +: DW]);
                            p = (d >= wa1[i] && d <= wb1[i]) || (d >= wa2[i] && d <= wb2[i]);
                        end
                        test_pass[i] = p;
                    end
                    test_timeout = (trial_no < wr_trials_exp) && (trial_no < 64) && tmask[trial_no];
                    trial_no++;
                    test_ack = 1;
                    wcnt = 0;
                end else wcnt++;
            end
        end
    end

    // Monitor: compare queued expectations once the run ends.
    initial begin
        bit busy_prev;
        item_t it;
        busy_prev = 0;
        forever begin
            @(negedge clk);
            if (busy_prev && !busy)
                while (sbq.size() > 0) begin
                    it = sbq.pop_front();
                    check(it.tag, $sformatf("kind %0d lane %0d", it.kind, it.lane),
                          actual(it.kind, it.lane), it.exp);
                end
            busy_prev = busy;
        end
    end

    task automatic run_case(input logic [NL-1:0] en, input bit dqm, input int settle,
                            input int rl, input string ofs_tag, input string cnt_tag,
                            input bit poke);
        lane_en = en; dq_mode = dqm; settle_cnt = SW'(settle); resp_lat = rl; trial_no = 0;
        expect_run(en, dqm, ofs_tag, cnt_tag);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        if (poke) begin
            repeat (10) @(negedge clk);
            lane_en = '0; dq_mode = 0; start = 1;   // R12: must be ignored
            @(negedge clk); start = 0;
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) set_lane(i, 0, 0, 1, 0, 1, 0);
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check("R1", "status", int'(status), 0);
        check("R1", "test_req", int'(test_req), 0);
        check("R1", "busy", int'(busy), 0);
        check("R1", "outputs", int'(|{wr_lat, wr_ofs, dq_dly, lane_ok}), 0);

        // R4/R8: lanes pass at different offsets, latency 0.
        set_lane(0, 0, 0, 1, 0, 1, 0); set_lane(1, 0, 3, 1, 0, 1, 0);
        set_lane(2, 0, 7, 1, 0, 1, 0); set_lane(3, 0, 2, 1, 0, 1, 0);
        set_lane(4, 0, 5, 1, 0, 1, 0);
        run_case(5'b11111, 0, 0, 0, "R4", "R8", 0);

        // R6/R9: disabled lanes pass always, lane 2 needs latency 2.
        set_lane(0, 0, 1, 1, 0, 1, 0); set_lane(1, 0, 0, 1, 0, 1, 0);
        set_lane(2, 2, 4, 1, 0, 1, 0); set_lane(3, 0, 0, 1, 0, 1, 0);
        set_lane(4, 0, 6, 1, 0, 1, 0);
        run_case(5'b10101, 0, 3, 2, "R6", "R6", 0);

        // R7: lane 3 never passes.
        set_lane(0, 0, 1, 1, 0, 1, 0); set_lane(1, 1, 2, 1, 0, 1, 0);
        set_lane(2, 0, 0, 1, 0, 1, 0); set_lane(3, 4, 0, 1, 0, 1, 0);
        set_lane(4, 3, 7, 1, 0, 1, 0);
        run_case(5'b11111, 0, 1, 1, "R7", "R7", 0);

        // R5: timeouts on trials 0 and 2.
        tmask = 64'h5;
        set_lane(0, 0, 0, 1, 0, 1, 0); set_lane(1, 0, 2, 1, 0, 1, 0);
        run_case(5'b00011, 0, 0, 0, "R5", "R5", 0);
        tmask = '0;

        // R10/R11/R12: data-delay windows, with a start pulse while busy.
        set_lane(0, 0, 1, 3, 9, 1, 0);   set_lane(1, 0, 1, 0, 0, 1, 0);
        set_lane(2, 0, 1, 1, 0, 1, 0);   set_lane(3, 0, 1, 5, 7, 10, 12);
        set_lane(4, 0, 1, 14, 15, 1, 0);
        run_case(5'b11111, 1, 1, 1, "R4", "R12", 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule